// File: doc/BRIEF.md
# Receive Descriptor Writeback Engine

This block is the hardware half of a receive descriptor ring. Software keeps a ring of 16-byte slots in memory. Each slot starts out holding a buffer address, and software hands slots back by moving a consumer index. For every frame presented on its input stream, the engine claims the slot under its producer index. It overwrites that slot with a completion record, then steps the producer index. The completion record carries the stored length and a status word whose ready flag software polls in memory.

Frames arrive as a length plus an error code on a valid/ready stream. Back-pressure rules: the engine raises `frm_ready` only while it is idle, the ring is enabled, and either a free slot exists or the drop policy is selected. A frame is taken on any rising edge where `frm_valid` and `frm_ready` are both high. The memory side is a valid/ready stream of 32-bit writes. Once `mem_wr_valid` is raised, its address and data stay unchanged until the consumer accepts them with `mem_wr_ready`.

Configuration uses a plain write port whose register window is placed by ring number. Payload movement, hashing, checksum and VLAN extraction lie outside the block, so the engine writes zero into those fields.

Top module: `rxr_wb_engine`

## Requirements
- R1: After reset, `prod_idx` is 0, `drop_cnt` is 0, and both `frm_ready` and `mem_wr_valid` are low.
- R2: A frame is accepted only while the ring enable bit (bit 31 of the mode register) is set and no descriptor write is in progress. Whenever `frm_ready` is high, `mem_wr_valid` is low.
- R3: An accepted frame produces exactly four 32-bit writes, at byte offsets 0, 4, 8 and 12 from the slot address. The slot address is base + 16 × `prod_idx`. The writes go out in that offset order, and the words at offsets 0 and 4 are zero.
- R4: The word at offset 8 carries the stored length in bits 15:0 and zero in bits 31:16.
- R5: The word at offset 12 is the status word. Bit 31 (final) and bit 30 (ready) are 1, bits 23:16 hold the error code, and all other bits are 0. It is always the last of the four writes.
- R6: A frame longer than the buffer-size register is stored with length equal to the buffer size. Its error code is the input error code ORed with 0x80. A frame of exactly the buffer size is not truncated.
- R7: `prod_idx` steps on the edge where the status write is accepted. It wraps to 0 when the step would reach the ring-length register.
- R8: The ring is full when the producer index after a step would equal the consumer index. With the drop bit (bit 0 of the mode register) clear, `frm_ready` stays low while the ring is full.
- R9: With the drop bit set, a frame offered to a full ring is accepted and nothing is written. `drop_cnt` increments by one and `prod_idx` is unchanged.
- R10: While `mem_wr_valid` is high and `mem_wr_ready` is low, the next cycle keeps `mem_wr_valid` high with the same address and data.
- R11: Registers sit at 0x8000 + 0x100 + 0x200 × ring number. The offsets within that window are: mode 0x00, buffer size 0x08, consumer index 0x0C, base low 0x10, base high 0x14, producer index 0x18, ring length 0x20. A write to any other address leaves every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 16 | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| frm_valid | input | 1 | Frame descriptor request valid |
| frm_ready | output | 1 | Engine can take a frame |
| frm_len | input | LEN_W | Received frame length in bytes |
| frm_err | input | 8 | Receive error code |
| mem_wr_valid | output | 1 | Memory write request valid |
| mem_wr_ready | input | 1 | Memory write accepted |
| mem_wr_addr | output | ADDR_W | Memory write byte address |
| mem_wr_data | output | 32 | Memory write data, little-endian word |
| prod_idx | output | IDX_W | Current producer index |
| drop_cnt | output | CNT_W | Count of frames dropped on a full ring |

## Verification
The collision that matters is software handing back a slot in the very cycle the engine is deciding, against a full ring, whether a waiting frame may enter. The bench holds a frame on the input while the ring is full and then writes the consumer index. The cycle-accurate model says the frame may enter only on the edge after the write lands, and `frm_ready` is compared against that model every cycle. A random phase repeats the collision: consumer-index writes, policy flips and memory stalls land on arbitrary cycles. It also lets the final status write coincide with a new frame arriving.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  // Register window placement: base + type stride + ring stride.
  localparam int unsigned RING_WIN_BASE = 32'h8000;
  localparam int unsigned TYPE_STRIDE   = 32'h100;
  localparam int unsigned RING_STRIDE   = 32'h200;
  localparam int unsigned RX_TYPE       = 1;

  // Offsets inside one ring window.
  localparam logic [5:0] OFF_MODE  = 6'h00;
  localparam logic [5:0] OFF_BSIZE = 6'h08;
  localparam logic [5:0] OFF_CONS  = 6'h0C;
  localparam logic [5:0] OFF_BASEL = 6'h10;
  localparam logic [5:0] OFF_BASEH = 6'h14;
  localparam logic [5:0] OFF_PROD  = 6'h18;
  localparam logic [5:0] OFF_RLEN  = 6'h20;

  localparam int unsigned MODE_EN_BIT   = 31;
  localparam int unsigned MODE_DROP_BIT = 0;

  localparam int unsigned ERR_W       = 8;
  localparam int unsigned LEN_FIELD_W = 16;
  localparam int unsigned SLOT_SHIFT  = 4;   // 16-byte slots

  typedef enum logic [2:0] {
    WB_IDLE,
    WB_CSUM,   // offset 0: checksum + parse summary
    WB_HASH,   // offset 4: hash
    WB_LEN,    // offset 8: length + vlan
    WB_STAT    // offset 12: status word, always last
  } wb_state_e;

  function automatic logic [31:0] make_status(input logic [ERR_W-1:0] err);
    return {2'b11, 6'b0, err, 16'h0};
  endfunction
endpackage

// File: rtl/rxr_cfg_regs.sv
module rxr_cfg_regs
  import rxr_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int IDX_W   = 16,
  parameter int LEN_W   = 16,
  parameter int RING_ID = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [15:0]       cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic              ring_en,
  output logic              drop_mode,
  output logic [LEN_W-1:0]  buf_size,
  output logic [IDX_W-1:0]  cons_idx,
  output logic [IDX_W-1:0]  ring_len,
  output logic [ADDR_W-1:0] ring_base,
  output logic              prod_load,
  output logic [IDX_W-1:0]  prod_load_val
);
  localparam logic [15:0] WIN =
    16'(RING_WIN_BASE + RX_TYPE * TYPE_STRIDE + RING_ID * RING_STRIDE);

  logic       win_hit;
  logic [5:0] off;
  logic [31:0] base_lo_q;

  assign win_hit = cfg_we && (cfg_addr[15:6] == WIN[15:6]);
  assign off     = cfg_addr[5:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ring_en   <= 1'b0;
      drop_mode <= 1'b0;
      buf_size  <= '0;
      cons_idx  <= '0;
      ring_len  <= '0;
      base_lo_q <= '0;
    end else if (win_hit) begin
      case (off)
        OFF_MODE: begin
          ring_en   <= cfg_wdata[MODE_EN_BIT];
          drop_mode <= cfg_wdata[MODE_DROP_BIT];
        end
        OFF_BSIZE: buf_size  <= cfg_wdata[LEN_W-1:0];
        OFF_CONS:  cons_idx  <= cfg_wdata[IDX_W-1:0];
        OFF_RLEN:  ring_len  <= cfg_wdata[IDX_W-1:0];
        OFF_BASEL: base_lo_q <= cfg_wdata;
        default: ;
      endcase
    end
  end

  generate
    if (ADDR_W > 32) begin : g_wide_base
      logic [ADDR_W-33:0] base_hi_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          base_hi_q <= '0;
        else if (win_hit && off == OFF_BASEH)
          base_hi_q <= cfg_wdata[ADDR_W-33:0];
      end
      assign ring_base = {base_hi_q, base_lo_q};
    end else begin : g_narrow_base
      assign ring_base = base_lo_q[ADDR_W-1:0];
    end
  endgenerate

  assign prod_load     = win_hit && (off == OFF_PROD);
  assign prod_load_val = cfg_wdata[IDX_W-1:0];
endmodule

// File: rtl/rxr_slot_track.sv
module rxr_slot_track
  import rxr_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int IDX_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  ring_len,
  input  logic [IDX_W-1:0]  cons_idx,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic              advance,
  input  logic              load,
  input  logic [IDX_W-1:0]  load_val,
  output logic [IDX_W-1:0]  prod_idx,
  output logic              ring_full,
  output logic [ADDR_W-1:0] slot_addr
);
  logic [IDX_W-1:0] inc;
  logic [IDX_W-1:0] nxt;

  assign inc       = prod_idx + IDX_W'(1);
  assign nxt       = (inc == ring_len) ? '0 : inc;
  assign ring_full = (nxt == cons_idx);
  assign slot_addr = ring_base + (ADDR_W'(prod_idx) << SLOT_SHIFT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      prod_idx <= '0;
    else if (load)
      prod_idx <= load_val;     // software write wins over a step
    else if (advance)
      prod_idx <= nxt;
  end
endmodule

// File: rtl/rxr_wb_seq.sv
module rxr_wb_seq
  import rxr_pkg::*;
#(
  parameter int              ADDR_W     = 64,
  parameter int              LEN_W      = 16,
  parameter int              CNT_W      = 16,
  parameter logic [ERR_W-1:0] TRUNC_CODE = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ring_en,
  input  logic              drop_mode,
  input  logic              ring_full,
  input  logic [LEN_W-1:0]  buf_size,
  input  logic [ADDR_W-1:0] slot_addr,
  input  logic              frm_valid,
  output logic              frm_ready,
  input  logic [LEN_W-1:0]  frm_len,
  input  logic [ERR_W-1:0]  frm_err,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [31:0]       mem_wr_data,
  output logic              advance,
  output logic [CNT_W-1:0]  drop_cnt
);
  wb_state_e         state;
  logic [ADDR_W-1:0] desc_q;
  logic [LEN_W-1:0]  len_q;
  logic [ERR_W-1:0]  err_q;
  logic              accept;
  logic              trunc;
  logic [1:0]        word_sel;

  assign frm_ready = (state == WB_IDLE) && ring_en && (!ring_full || drop_mode);
  assign accept    = frm_valid && frm_ready;
  assign trunc     = frm_len > buf_size;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= WB_IDLE;
      desc_q   <= '0;
      len_q    <= '0;
      err_q    <= '0;
      drop_cnt <= '0;
    end else begin
      case (state)
        WB_IDLE: begin
          if (accept) begin
            if (ring_full) begin
              drop_cnt <= drop_cnt + CNT_W'(1);
            end else begin
              desc_q <= slot_addr;
              len_q  <= trunc ? buf_size : frm_len;
              err_q  <= frm_err | (trunc ? TRUNC_CODE : '0);
              state  <= WB_CSUM;
            end
          end
        end
        WB_CSUM: if (mem_wr_ready) state <= WB_HASH;
        WB_HASH: if (mem_wr_ready) state <= WB_LEN;
        WB_LEN:  if (mem_wr_ready) state <= WB_STAT;
        WB_STAT: if (mem_wr_ready) state <= WB_IDLE;
        default: state <= WB_IDLE;
      endcase
    end
  end

  always_comb begin
    word_sel    = 2'd0;
    mem_wr_data = '0;
    case (state)
      WB_HASH: word_sel = 2'd1;
      WB_LEN: begin
        word_sel    = 2'd2;
        mem_wr_data = {16'h0, LEN_FIELD_W'(len_q)};
      end
      WB_STAT: begin
        word_sel    = 2'd3;
        mem_wr_data = make_status(err_q);
      end
      default: ;
    endcase
  end

  assign mem_wr_valid = (state != WB_IDLE);
  assign mem_wr_addr  = desc_q + ADDR_W'({word_sel, 2'b00});
  assign advance      = (state == WB_STAT) && mem_wr_ready;
endmodule

// File: rtl/rxr_wb_engine.sv
module rxr_wb_engine
  import rxr_pkg::*;
#(
  parameter int               ADDR_W     = 64,
  parameter int               IDX_W      = 16,
  parameter int               LEN_W      = 16,
  parameter int               CNT_W      = 16,
  parameter int               RING_ID    = 0,
  parameter logic [ERR_W-1:0] TRUNC_CODE = 8'h80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [15:0]       cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              frm_valid,
  output logic              frm_ready,
  input  logic [LEN_W-1:0]  frm_len,
  input  logic [ERR_W-1:0]  frm_err,
  output logic              mem_wr_valid,
  input  logic              mem_wr_ready,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [31:0]       mem_wr_data,
  output logic [IDX_W-1:0]  prod_idx,
  output logic [CNT_W-1:0]  drop_cnt
);
  logic              ring_en_w;
  logic              drop_mode_w;
  logic [LEN_W-1:0]  buf_size_w;
  logic [IDX_W-1:0]  cons_idx_w;
  logic [IDX_W-1:0]  ring_len_w;
  logic [ADDR_W-1:0] ring_base_w;
  logic              prod_load_w;
  logic [IDX_W-1:0]  prod_load_val_w;
  logic              full_w;
  logic [ADDR_W-1:0] slot_addr_w;
  logic              advance_w;

  rxr_cfg_regs #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .LEN_W(LEN_W), .RING_ID(RING_ID)
  ) u_regs (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_we        (cfg_we),
    .cfg_addr      (cfg_addr),
    .cfg_wdata     (cfg_wdata),
    .ring_en       (ring_en_w),
    .drop_mode     (drop_mode_w),
    .buf_size      (buf_size_w),
    .cons_idx      (cons_idx_w),
    .ring_len      (ring_len_w),
    .ring_base     (ring_base_w),
    .prod_load     (prod_load_w),
    .prod_load_val (prod_load_val_w)
  );

  rxr_slot_track #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .ring_len  (ring_len_w),
    .cons_idx  (cons_idx_w),
    .ring_base (ring_base_w),
    .advance   (advance_w),
    .load      (prod_load_w),
    .load_val  (prod_load_val_w),
    .prod_idx  (prod_idx),
    .ring_full (full_w),
    .slot_addr (slot_addr_w)
  );

  rxr_wb_seq #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W), .TRUNC_CODE(TRUNC_CODE)
  ) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .ring_en      (ring_en_w),
    .drop_mode    (drop_mode_w),
    .ring_full    (full_w),
    .buf_size     (buf_size_w),
    .slot_addr    (slot_addr_w),
    .frm_valid    (frm_valid),
    .frm_ready    (frm_ready),
    .frm_len      (frm_len),
    .frm_err      (frm_err),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_ready (mem_wr_ready),
    .mem_wr_addr  (mem_wr_addr),
    .mem_wr_data  (mem_wr_data),
    .advance      (advance_w),
    .drop_cnt     (drop_cnt)
  );
endmodule

// File: rtl/rxr_wb_engine_chk.sv
module rxr_wb_engine_chk #(
  parameter int ADDR_W = 64,
  parameter int IDX_W  = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_we,
  input logic              frm_valid,
  input logic              frm_ready,
  input logic              mem_wr_valid,
  input logic              mem_wr_ready,
  input logic [ADDR_W-1:0] mem_wr_addr,
  input logic [31:0]       mem_wr_data,
  input logic [IDX_W-1:0]  prod_idx,
  input logic [CNT_W-1:0]  drop_cnt,
  input logic              full,
  input logic              drop_mode
);
  // R10: a stalled write request holds its contents
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && !mem_wr_ready |=>
      mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data));

  // R2: no new frame is offered a slot while a writeback is pending
  p_idle_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frm_ready |-> !mem_wr_valid);

  // R5: the status word always carries final and ready
  p_status_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && mem_wr_addr[3:0] == 4'hC |-> mem_wr_data[31:30] == 2'b11);

  // R3: checksum and hash words are zero
  p_zero_words_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid && !mem_wr_addr[3] |-> mem_wr_data == 32'h0);

  // R8: stall policy keeps the input closed on a full ring
  p_stall_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    full && !drop_mode |-> !frm_ready);

  // R9: a frame taken on a full ring bumps the drop counter
  p_drop_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frm_valid && frm_ready && full |=> drop_cnt == $past(drop_cnt) + CNT_W'(1));

  // R7: producer index moves only with the status write or a software load
  p_prod_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we && !(mem_wr_valid && mem_wr_ready && mem_wr_addr[3:0] == 4'hC)
      |=> $stable(prod_idx));
endmodule

bind rxr_wb_engine rxr_wb_engine_chk #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_we       (cfg_we),
  .frm_valid    (frm_valid),
  .frm_ready    (frm_ready),
  .mem_wr_valid (mem_wr_valid),
  .mem_wr_ready (mem_wr_ready),
  .mem_wr_addr  (mem_wr_addr),
  .mem_wr_data  (mem_wr_data),
  .prod_idx     (prod_idx),
  .drop_cnt     (drop_cnt),
  .full         (full_w),
  .drop_mode    (drop_mode_w)
);

// File: tb/rxr_wb_engine_tb.sv
module rxr_wb_engine_tb;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        frm_valid = 1'b0;
  logic        frm_ready;
  logic [15:0] frm_len = '0;
  logic [7:0]  frm_err = '0;
  logic        mem_wr_valid;
  logic        mem_wr_ready = 1'b0;
  logic [63:0] mem_wr_addr;
  logic [31:0] mem_wr_data;
  logic [15:0] prod_idx;
  logic [15:0] drop_cnt;

  always #2.5 clk = ~clk;   // 200 MHz

  rxr_wb_engine u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .frm_valid(frm_valid), .frm_ready(frm_ready),
    .frm_len(frm_len), .frm_err(frm_err), .mem_wr_valid(mem_wr_valid),
    .mem_wr_ready(mem_wr_ready), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .prod_idx(prod_idx), .drop_cnt(drop_cnt)
  );

  localparam logic [31:0] EN = 32'h8000_0000;

  int n_cmp = 0;
  int n_bad = 0;
  bit run = 1'b0;

  typedef struct {
    logic [63:0] a;
    logic [31:0] d;
    string       tag;
  } wr_t;
  wr_t wq[$];

  // Behavioural reference state
  bit          m_en, m_drop;
  logic [15:0] m_bsz, m_ci, m_len, m_pi, m_drops;
  logic [63:0] m_base;

  function automatic logic [15:0] m_next();
    logic [15:0] s = m_pi + 16'd1;
    return (s == m_len) ? 16'd0 : s;
  endfunction

  function automatic bit m_full();
    return m_next() == m_ci;
  endfunction

  function automatic bit m_ready();
    return m_en && wq.size() == 0 && (!m_full() || m_drop);
  endfunction

  task automatic note(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  // Model update on each edge, from inputs and model state only
  bit          p_rdy, p_full, p_mhs;
  logic [15:0] p_len;
  logic [7:0]  p_err;
  logic [63:0] p_slot;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_drop = 0; m_bsz = 0; m_ci = 0; m_len = 0; m_pi = 0;
      m_drops = 0; m_base = 0; wq.delete();
    end else begin
      p_full = m_full();
      p_rdy  = m_ready();
      p_mhs  = wq.size() != 0 && mem_wr_ready;
      if (frm_valid && p_rdy) begin
        if (p_full) m_drops = m_drops + 16'd1;
        else begin
          p_len  = (frm_len > m_bsz) ? m_bsz : frm_len;
          p_err  = frm_err | ((frm_len > m_bsz) ? 8'h80 : 8'h00);
          p_slot = m_base + {44'd0, m_pi, 4'd0};
          wq.push_back('{p_slot,        32'h0, "R3"});
          wq.push_back('{p_slot + 64'd4, 32'h0, "R3"});
          wq.push_back('{p_slot + 64'd8, {16'h0, p_len},
                         (frm_len > m_bsz) ? "R6" : "R4"});
          wq.push_back('{p_slot + 64'd12, {2'b11, 6'b0, p_err, 16'h0},
                         (frm_len > m_bsz) ? "R6" : "R5"});
        end
      end else if (p_mhs) begin
        void'(wq.pop_front());
        if (wq.size() == 0) m_pi = m_next();
      end
      if (cfg_we) begin
        case (cfg_addr)   // R11 register map; anything else ignored
          16'h8100: begin m_en = cfg_wdata[31]; m_drop = cfg_wdata[0]; end
          16'h8108: m_bsz = cfg_wdata[15:0];
          16'h810C: m_ci = cfg_wdata[15:0];
          16'h8110: m_base[31:0] = cfg_wdata;
          16'h8114: m_base[63:32] = cfg_wdata;
          16'h8118: m_pi = cfg_wdata[15:0];
          16'h8120: m_len = cfg_wdata[15:0];
          default: ;
        endcase
      end
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && run) begin
      note(frm_ready == m_ready(), m_full() ? "R8" : "R2", "frm_ready",
           64'(frm_ready), 64'(m_ready()));
      note(mem_wr_valid == (wq.size() != 0), "R3", "mem_wr_valid",
           64'(mem_wr_valid), 64'(wq.size() != 0));
      if (mem_wr_valid && wq.size() != 0) begin
        note(mem_wr_addr == wq[0].a, "R3", "mem_wr_addr", mem_wr_addr, wq[0].a);
        note(mem_wr_data == wq[0].d, wq[0].tag, "mem_wr_data",
             64'(mem_wr_data), 64'(wq[0].d));
      end
      note(prod_idx == m_pi, "R7", "prod_idx", 64'(prod_idx), 64'(m_pi));
      note(drop_cnt == m_drops, "R9", "drop_cnt", 64'(drop_cnt), 64'(m_drops));
    end
  end

  // Memory side back-pressure, stalls about a quarter of cycles (R10)
  always @(negedge clk) mem_wr_ready = ($urandom % 4) != 0;

  task automatic cfg_write(input logic [15:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic send_frame(input logic [15:0] l, input logic [7:0] e);
    frm_valid = 1'b1; frm_len = l; frm_err = e;
    do @(posedge clk); while (!frm_ready);
    @(negedge clk);
    frm_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (mem_wr_valid) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R7 watchdog: cycles=100000 expected=completion");
    finish_run();
  end

  bit hs;
  int r;
  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    run = 1'b1;
    @(negedge clk);
    // R1 reset state
    note(prod_idx == 0, "R1", "prod_idx", 64'(prod_idx), 0);
    note(drop_cnt == 0, "R1", "drop_cnt", 64'(drop_cnt), 0);
    note(!frm_ready, "R1", "frm_ready", 64'(frm_ready), 0);
    note(!mem_wr_valid, "R1", "mem_wr_valid", 64'(mem_wr_valid), 0);

    cfg_write(16'h8110, 32'h0000_1000);
    cfg_write(16'h8114, 32'h0000_0001);
    cfg_write(16'h8120, 32'd4);
    cfg_write(16'h8108, 32'd1536);
    cfg_write(16'h810C, 32'd0);
    frm_valid = 1'b1; frm_len = 16'd10;
    @(negedge clk);
    note(!frm_ready, "R2", "ready while disabled", 64'(frm_ready), 0);
    frm_valid = 1'b0;
    cfg_write(16'h8100, EN);

    send_frame(16'd64, 8'h00);       // R4 plain frame
    send_frame(16'd1536, 8'h00);     // R6 boundary: equal, no truncation
    send_frame(16'd2000, 8'h02);     // R6 truncated, error 0x82
    wait_idle();
    note(prod_idx == 3, "R7", "prod_idx after three", 64'(prod_idx), 3);

    // R8 ring full, stall policy; then a consumer return lands
    frm_valid = 1'b1; frm_len = 16'd300; frm_err = 8'h00;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      note(!frm_ready, "R8", "ready on full ring", 64'(frm_ready), 0);
    end
    cfg_write(16'h810C, 32'd2);
    do @(posedge clk); while (!frm_ready);
    @(negedge clk);
    frm_valid = 1'b0;
    wait_idle();
    note(prod_idx == 0, "R7", "prod_idx wrap", 64'(prod_idx), 0);

    // R9 drop policy
    cfg_write(16'h8100, EN | 32'd1);
    send_frame(16'd80, 8'h00);
    wait_idle();
    send_frame(16'd90, 8'h05);
    note(drop_cnt == 1, "R9", "drop_cnt", 64'(drop_cnt), 1);
    note(prod_idx == 1, "R9", "prod_idx after drop", 64'(prod_idx), 1);
    note(!mem_wr_valid, "R9", "no write on drop", 64'(mem_wr_valid), 0);

    // R11 writes outside the map change nothing
    cfg_write(16'h8000, 32'h0);
    cfg_write(16'h8104, 32'h0);
    cfg_write(16'h8308, 32'd16);
    cfg_write(16'h8124, 32'h0);
    note(frm_ready, "R11", "ready after stray writes", 64'(frm_ready), 1);
    cfg_write(16'h810C, 32'd0);
    send_frame(16'd200, 8'h00);
    wait_idle();
    note(prod_idx == 2, "R11", "prod_idx", 64'(prod_idx), 2);

    // Random phase: collisions of consumer returns, policy and stalls
    for (int i = 0; i < 3000; i++) begin
      @(posedge clk);
      hs = frm_valid && frm_ready;
      @(negedge clk);
      if (hs) frm_valid = 1'b0;
      if (!frm_valid && ($urandom % 3) == 0) begin
        frm_valid = 1'b1;
        frm_len   = 16'(($urandom % 2100) + 1);
        frm_err   = (($urandom % 4) == 0) ? 8'($urandom % 16) : 8'h00;
      end
      cfg_we = 1'b0;
      r = $urandom % 16;
      if (r == 0) begin
        cfg_we = 1'b1; cfg_addr = 16'h810C; cfg_wdata = 32'($urandom % 4);
      end else if (r == 1) begin
        cfg_we = 1'b1; cfg_addr = 16'h8100;
        cfg_wdata = ((($urandom % 8) == 0) ? 32'h0 : EN) | 32'($urandom % 2);
      end
    end
    cfg_we = 1'b0;
    @(negedge clk);
    cfg_write(16'h8100, EN | 32'd1);
    if (frm_valid) begin
      do @(posedge clk); while (!frm_ready);
      @(negedge clk);
      frm_valid = 1'b0;
    end
    wait_idle();
    repeat (10) @(negedge clk);
    finish_run();
  end
endmodule